// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block brings a DRAM array out of power-up and then keeps its contents alive. After reset it keeps every row and column strobe inactive for a fixed quiet time. It then runs a burst of refresh cycles in which CAS is lowered before RAS, so the memory's own row counter supplies the row. Only after that does it release the host. From then on it raises a refresh request at an even pace, so that the whole row budget is refreshed inside every retention window.

Each refresh goes through a request/grant handshake with the page-mode access controller. While the controller holds the grant, the scheduler drives all RAS and CAS lines itself and keeps the write enable inactive. A request that cannot be granted at once because an access is running is counted as outstanding. When more requests are outstanding than a configured limit, the scheduler raises a sticky error.

All timing comes from the clock frequency in kHz and from times given in ns or µs. Each is turned into a cycle count. Strobe times are rounded up, and the refresh interval is rounded down so the window is never overrun.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset release, for at least `PAUSE_CYC` cycles (`ceil(PAUSE_US*CLK_KHZ/1000)`), `ref_req` stays low and every `ras_n`/`cas_n` line stays high (1 = inactive).
- R2: `host_hold` is 1 from reset until exactly `INIT_REFS` refresh cycles (RAS falling edges) have completed. It then falls and stays 0 until the next reset.
- R3: At every RAS falling edge, CAS was already low in the preceding cycle.
- R4: CAS only falls while RAS is high and was high in the preceding cycle.
- R5: Whenever RAS is low, CAS is low, so CAS stays low after RAS falls until RAS rises again.
- R6: RAS stays low for at least `ceil(max(60 ns, 10 ns)*f)` cycles (3 at 50 MHz). It stays high for at least the precharge count (3 at 50 MHz) between two RAS pulses, which makes a full cycle last at least 110 ns.
- R7: `we_n` is 1 at all times.
- R8: After `host_hold` falls, one refresh is requested every `floor(CLK_KHZ*WINDOW_US/(1000*REF_ROWS))` cycles.
- R9: A strobe is low only while `ref_ack` and `own_strobes` are both 1.
- R10: Once raised, `ref_req` stays high while `ref_ack` is 0.
- R11: Refreshes that fall due while no grant is given are remembered, up to `MAX_PEND` of them. They are run back to back once grants resume, and any beyond `MAX_PEND` are dropped.
- R12: `ovf_err` rises when an interval expires while `MAX_PEND` refreshes are already outstanding. It stays 1 until reset, and stays 0 when no more than `MAX_PEND` are outstanding.
- R13: All `ras_n` lines carry the same value as each other, and all `cas_n` lines carry the same value as each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ack | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request to the access controller |
| own_strobes | output | 1 | 1 while this block drives the strobes under grant |
| ras_n | output | NRAS | Row strobes, active low |
| cas_n | output | NCAS | Column strobes, active low |
| we_n | output | 1 | Write enable, held inactive |
| host_hold | output | 1 | 1 while host traffic must wait for initialisation |
| ovf_err | output | 1 | Sticky outstanding-refresh overflow flag |

## Verification
The hardest state to reach is the outstanding-request limit, since the block only shows it through later strobe activity and the error flag. The bench's controller model refuses grants for a set number of cycles, starting only when no refresh is under way. A stall of two and a half intervals shows that deferred refreshes are kept and then run without an error. A stall of five intervals forces the overflow, and the number of refreshes that follow the release shows the cap. Around these directed stalls, grants arrive after random delays, and the bench checks strobe shape and pacing against its own computed interval.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_SETUP,
        SQ_CAS_LEAD,
        SQ_ROW_LOW,
        SQ_PRECH,
        SQ_RELEASE
    } seq_state_e;

    typedef struct packed {
        logic req;
        logic drive;
        logic row_low;
        logic col_low;
    } strobe_drive_t;

    localparam int unsigned T_RPC_NS = 5;
    localparam int unsigned T_CSR_NS = 10;
    localparam int unsigned T_CHR_NS = 10;
    localparam int unsigned T_RAS_NS = 60;
    localparam int unsigned T_RP_NS  = 40;
    localparam int unsigned T_RC_NS  = 110;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned khz);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(ns) * longint'(khz);
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        return (cyc == 0) ? 1 : int'(cyc);
    endfunction

    function automatic int unsigned refresh_gap(input int unsigned khz,
                                                input int unsigned window_us,
                                                input int unsigned rows);
        longint unsigned g;
        g = (longint'(khz) * longint'(window_us)) / (longint'(rows) * 64'd1000);
        return (g == 0) ? 1 : int'(g);
    endfunction

endpackage

// File: rtl/dref_init.sv
module dref_init #(
    parameter int unsigned PAUSE_CYC = 10000,
    parameter int unsigned INIT_REFS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_done,
    output logic init_load,
    output logic ready
);
    localparam int PCW = $clog2(PAUSE_CYC + 1);
    localparam int DW  = $clog2(INIT_REFS + 1);

    logic [PCW-1:0] pcnt_q;
    logic           paused_q;
    logic [DW-1:0]  dcnt_q;
    logic           ready_q;

    assign init_load = !paused_q && (pcnt_q == PCW'(PAUSE_CYC - 1));
    assign ready     = ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q   <= '0;
            paused_q <= 1'b0;
            dcnt_q   <= '0;
            ready_q  <= 1'b0;
        end else begin
            if (!paused_q) begin
                pcnt_q <= pcnt_q + 1'b1;
                if (init_load) paused_q <= 1'b1;
            end
            if (paused_q && !ready_q && cyc_done) begin
                dcnt_q <= dcnt_q + 1'b1;
                if (dcnt_q == DW'(INIT_REFS - 1)) ready_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dref_pacer.sv
module dref_pacer
    import dram_refresh_pkg::*;
#(
    parameter int unsigned GAP_CYC   = 781,
    parameter int unsigned INIT_REFS = 8,
    parameter int unsigned MAX_PEND  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic init_load,
    input  logic cyc_done,
    output logic need,
    output logic ovf_err
);
    localparam int TW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(imax(INIT_REFS, MAX_PEND) + 1);

    logic [TW-1:0] tmr_q;
    logic [PW-1:0] pend_q;
    logic          err_q;
    logic          tick;

    assign tick    = run && (tmr_q == TW'(GAP_CYC - 1));
    assign need    = (pend_q != '0);
    assign ovf_err = err_q;

    always_ff @(posedge clk) begin
        if (rst || !run)       tmr_q <= '0;
        else if (tick)         tmr_q <= '0;
        else                   tmr_q <= tmr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            err_q  <= 1'b0;
        end else if (init_load) begin
            pend_q <= PW'(INIT_REFS);
        end else begin
            unique case ({tick, cyc_done})
                2'b10: begin
                    if (pend_q < PW'(MAX_PEND)) pend_q <= pend_q + 1'b1;
                    else                        err_q  <= 1'b1;
                end
                2'b01: if (pend_q != '0) pend_q <= pend_q - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dram_refresh_pkg::*;
#(
    parameter int unsigned NRAS      = 2,
    parameter int unsigned NCAS      = 4,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned LEAD_CYC  = 1,
    parameter int unsigned ROW_CYC   = 3,
    parameter int unsigned PRECH_CYC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            need,
    input  logic            ack,
    output logic            req,
    output logic            own,
    output logic [NRAS-1:0] ras_n,
    output logic [NCAS-1:0] cas_n,
    output logic            we_n,
    output logic            cyc_done
);
    localparam int unsigned LONGEST = imax(imax(SETUP_CYC, LEAD_CYC), imax(ROW_CYC, PRECH_CYC));
    localparam int CW = $clog2(LONGEST + 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    strobe_drive_t drv;
    logic          last;

    assign last = (cnt_q == '0);

    always_comb begin
        state_d  = state_q;
        cnt_d    = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
        cyc_done = 1'b0;
        unique case (state_q)
            SQ_IDLE:     if (need && !ack) state_d = SQ_REQ;
            SQ_REQ:      if (ack) begin state_d = SQ_SETUP; cnt_d = CW'(SETUP_CYC - 1); end
            SQ_SETUP:    if (last) begin state_d = SQ_CAS_LEAD; cnt_d = CW'(LEAD_CYC - 1); end
            SQ_CAS_LEAD: if (last) begin state_d = SQ_ROW_LOW; cnt_d = CW'(ROW_CYC - 1); end
            SQ_ROW_LOW:  if (last) begin state_d = SQ_PRECH; cnt_d = CW'(PRECH_CYC - 1); end
            SQ_PRECH:    if (last) begin state_d = SQ_RELEASE; cyc_done = 1'b1; end
            SQ_RELEASE:  if (!ack) state_d = SQ_IDLE;
            default:     state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        drv.req     = state_q inside {SQ_REQ, SQ_SETUP, SQ_CAS_LEAD, SQ_ROW_LOW, SQ_PRECH};
        drv.drive   = ack && (state_q inside {SQ_SETUP, SQ_CAS_LEAD, SQ_ROW_LOW, SQ_PRECH});
        drv.row_low = drv.drive && (state_q == SQ_ROW_LOW);
        drv.col_low = drv.drive && (state_q inside {SQ_CAS_LEAD, SQ_ROW_LOW});
    end

    assign req  = drv.req;
    assign own  = drv.drive;
    assign we_n = 1'b1;

    for (genvar r = 0; r < NRAS; r++) begin : g_row
        assign ras_n[r] = !drv.row_low;
    end
    for (genvar c = 0; c < NCAS; c++) begin : g_col
        assign cas_n[c] = !drv.col_low;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 50000,
    parameter int unsigned PAUSE_US  = 200,
    parameter int unsigned WINDOW_US = 32000,
    parameter int unsigned REF_ROWS  = 2048,
    parameter int unsigned INIT_REFS = 8,
    parameter int unsigned MAX_PEND  = 4,
    parameter int unsigned NRAS      = 2,
    parameter int unsigned NCAS      = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_ack,
    output logic            ref_req,
    output logic            own_strobes,
    output logic [NRAS-1:0] ras_n,
    output logic [NCAS-1:0] cas_n,
    output logic            we_n,
    output logic            host_hold,
    output logic            ovf_err
);
    localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_US * 1000, CLK_KHZ);
    localparam int unsigned GAP_CYC   = refresh_gap(CLK_KHZ, WINDOW_US, REF_ROWS);
    localparam int unsigned SETUP_CYC = ns_to_cyc(T_RPC_NS, CLK_KHZ);
    localparam int unsigned LEAD_CYC  = ns_to_cyc(T_CSR_NS, CLK_KHZ);
    localparam int unsigned ROW_CYC   = imax(ns_to_cyc(T_RAS_NS, CLK_KHZ), ns_to_cyc(T_CHR_NS, CLK_KHZ));
    localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_KHZ);
    localparam int unsigned PRECH_CYC = imax(ns_to_cyc(T_RP_NS, CLK_KHZ),
                                             (RC_CYC > ROW_CYC) ? RC_CYC - ROW_CYC : 1);

    logic init_load, ready, need, cyc_done;

    dref_init #(
        .PAUSE_CYC (PAUSE_CYC),
        .INIT_REFS (INIT_REFS)
    ) u_init (
        .clk       (clk),
        .rst       (rst),
        .cyc_done  (cyc_done),
        .init_load (init_load),
        .ready     (ready)
    );

    dref_pacer #(
        .GAP_CYC   (GAP_CYC),
        .INIT_REFS (INIT_REFS),
        .MAX_PEND  (MAX_PEND)
    ) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .run       (ready),
        .init_load (init_load),
        .cyc_done  (cyc_done),
        .need      (need),
        .ovf_err   (ovf_err)
    );

    dref_seq #(
        .NRAS      (NRAS),
        .NCAS      (NCAS),
        .SETUP_CYC (SETUP_CYC),
        .LEAD_CYC  (LEAD_CYC),
        .ROW_CYC   (ROW_CYC),
        .PRECH_CYC (PRECH_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .need     (need),
        .ack      (ref_ack),
        .req      (ref_req),
        .own      (own_strobes),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cyc_done (cyc_done)
    );

    assign host_hold = !ready;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int unsigned PAUSE_CYC = 10000,
    parameter int unsigned ROW_CYC   = 3,
    parameter int unsigned PRECH_CYC = 3,
    parameter int unsigned NRAS      = 2,
    parameter int unsigned NCAS      = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            ref_ack,
    input logic            ref_req,
    input logic            own_strobes,
    input logic [NRAS-1:0] ras_n,
    input logic [NCAS-1:0] cas_n,
    input logic            host_hold,
    input logic            ovf_err
);
    localparam int SW = $clog2(PAUSE_CYC + 2);

    logic [SW-1:0] since_q;
    logic [7:0]    lo_len_q, hi_len_q;
    logic          seen_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= '0;
            lo_len_q  <= '0;
            hi_len_q  <= '0;
            seen_lo_q <= 1'b0;
        end else begin
            if (since_q < SW'(PAUSE_CYC)) since_q <= since_q + 1'b1;
            if (!ras_n[0]) begin
                seen_lo_q <= 1'b1;
                hi_len_q  <= '0;
                if (lo_len_q != 8'hff) lo_len_q <= lo_len_q + 1'b1;
            end else begin
                lo_len_q <= '0;
                if (hi_len_q != 8'hff) hi_len_q <= hi_len_q + 1'b1;
            end
        end
    end

    // R1
    quiet_pause_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q < SW'(PAUSE_CYC)) |-> (!ref_req && ras_n == '1 && cas_n == '1));
    // R2
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        !host_hold |=> !host_hold);
    // R3
    cas_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> $past(cas_n[0] == 1'b0));
    // R4
    ras_idle_cas_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n[0]) |-> (ras_n[0] && $past(ras_n[0])));
    // R5
    cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n[0] |-> !cas_n[0]);
    // R6
    ras_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n[0]) |-> (lo_len_q >= 8'(ROW_CYC)));
    // R6
    ras_prech_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n[0]) && seen_lo_q) |-> (hi_len_q >= 8'(PRECH_CYC)));
    // R9
    grant_only_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n != '1 || cas_n != '1) |-> (ref_ack && own_strobes));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> ref_req);
    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);
    // R13
    lines_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .PAUSE_CYC (PAUSE_CYC),
    .ROW_CYC   (ROW_CYC),
    .PRECH_CYC (PRECH_CYC),
    .NRAS      (NRAS),
    .NCAS      (NCAS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_ack     (ref_ack),
    .ref_req     (ref_req),
    .own_strobes (own_strobes),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .host_hold   (host_hold),
    .ovf_err     (ovf_err)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    localparam int unsigned KHZ   = 50000;
    localparam int unsigned P_US  = 4;
    localparam int unsigned WIN   = 64;
    localparam int unsigned ROWS  = 32;
    localparam int unsigned INITN = 8;
    localparam int unsigned MAXP  = 3;

    function automatic int exp_pause();
        return int'((longint'(P_US) * 1000 * KHZ + 999_999) / 1_000_000);
    endfunction
    function automatic int exp_gap();
        return int'((longint'(KHZ) * WIN) / (longint'(ROWS) * 1000));
    endfunction
    function automatic int exp_refs(input int cycles);
        return cycles / exp_gap();
    endfunction

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_ack = 1'b0;
    logic       ref_req, own_strobes, we_n, host_hold, ovf_err;
    logic [1:0] ras_n;
    logic [3:0] cas_n;

    always #10 clk = ~clk;

    dram_refresh_sched #(
        .CLK_KHZ(KHZ), .PAUSE_US(P_US), .WINDOW_US(WIN), .REF_ROWS(ROWS),
        .INIT_REFS(INITN), .MAX_PEND(MAXP), .NRAS(2), .NCAS(4)
    ) u_dram_refresh_sched (
        .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_req(ref_req),
        .own_strobes(own_strobes), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .host_hold(host_hold), .ovf_err(ovf_err)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // controller model
    bit stall = 0;
    int max_dly = 6;
    initial begin
        int wait_left;
        void'($urandom(32'h5eed_0042));
        wait_left = 0;
        forever begin
            @(posedge clk); #2;
            if (rst || !ref_req) begin
                ref_ack = 1'b0;
                wait_left = $urandom_range(0, max_dly);
            end else if (!stall && !ref_ack) begin
                if (wait_left == 0) ref_ack = 1'b1;
                else wait_left--;
            end
        end
    end

    // strobe monitor
    int  cyc = 0, falls = 0, init_falls = 0;
    int  first_low = -1, first_req = -1;
    int  lo_run = 0, hi_run = 0;
    bit  prev_ras = 1, prev_cas = 1, cas_held = 1;
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; falls = 0; init_falls = 0; first_low = -1; first_req = -1;
            lo_run = 0; hi_run = 0; prev_ras = 1; prev_cas = 1; cas_held = 1;
        end else begin
            cyc++;
            if (first_req < 0 && ref_req) first_req = cyc;
            if (first_low < 0 && (ras_n != 2'b11 || cas_n != 4'hf)) first_low = cyc;
            if (prev_ras && !ras_n[0]) begin
                falls++;
                if (host_hold) init_falls++;
                chk(!prev_cas, "R3 cas low before ras fall", prev_cas, 0);
                chk(ras_n == 2'b00 && cas_n == 4'h0, "R13 lines together", {ras_n, cas_n}, 0);
                chk(we_n == 1'b1, "R7 we_n high", we_n, 1);
                chk(ref_ack && own_strobes, "R9 strobes under grant", {ref_ack, own_strobes}, 3);
                if (falls > 1) chk(hi_run >= 3, "R6 precharge width", hi_run, 3);
                lo_run = 0; cas_held = 1;
            end
            if (!prev_ras && ras_n[0]) begin
                chk(lo_run >= 3, "R6 ras low width", lo_run, 3);
                chk(cas_held, "R5 cas held while ras low", cas_held, 1);
                hi_run = 0;
            end
            if (prev_cas && !cas_n[0])
                chk(prev_ras && ras_n[0], "R4 ras high before cas fall", prev_ras, 1);
            if (!ras_n[0]) begin
                lo_run++;
                if (cas_n[0]) cas_held = 0;
            end else hi_run++;
            prev_ras = ras_n[0];
            prev_cas = cas_n[0];
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_quiet();
        int guard = 0;
        @(negedge clk);
        while ((ref_req || ref_ack) && guard < 200) begin
            @(negedge clk); guard++;
        end
    endtask

    initial begin
        int base, d, guard;
        repeat (4) @(negedge clk);
        chk(ras_n == 2'b11 && cas_n == 4'hf, "R1 reset strobes idle", {ras_n, cas_n}, 63);
        chk(!ref_req && host_hold && !ovf_err, "R2 reset hold/req/err", {ref_req, host_hold, ovf_err}, 2);
        rst = 1'b0;

        guard = 0;
        while (host_hold && guard < 2000) begin @(negedge clk); guard++; end
        chk(!host_hold, "R2 hold released", host_hold, 0);
        chk(init_falls == INITN, "R2 init burst count", init_falls, INITN);
        chk(first_req > exp_pause(), "R1 first request after pause", first_req, exp_pause() + 1);
        chk(first_low > exp_pause(), "R1 first strobe after pause", first_low, exp_pause() + 1);

        // random grant delays
        base = falls; wait_cyc(2000); d = falls - base;
        chk(d >= exp_refs(2000) - 1 && d <= exp_refs(2000) + 1, "R8 pace random grants", d, exp_refs(2000));

        // prompt grants
        max_dly = 0;
        base = falls; wait_cyc(1000); d = falls - base;
        chk(d >= exp_refs(1000) - 1 && d <= exp_refs(1000) + 1, "R8 pace prompt grants", d, exp_refs(1000));

        // short stall: kept, no error
        wait_quiet(); stall = 1; base = falls;
        wait_cyc(250);
        chk(falls == base, "R9 no strobe without grant", falls - base, 0);
        chk(ref_req, "R10 request held while refused", ref_req, 1);
        chk(!ovf_err, "R12 no error within limit", ovf_err, 0);
        stall = 0; base = falls; wait_cyc(60); d = falls - base;
        chk(d >= 2 && d <= 4, "R11 deferred refreshes run", d, 3);

        // long stall: overflow
        wait_quiet(); stall = 1;
        wait_cyc(500);
        chk(ovf_err, "R12 overflow flagged", ovf_err, 1);
        stall = 0; base = falls; wait_cyc(60); d = falls - base;
        chk(d >= MAXP && d <= MAXP + 1, "R11 capped backlog", d, MAXP);
        base = falls; wait_cyc(400); d = falls - base;
        chk(ovf_err, "R12 error sticky", ovf_err, 1);
        chk(d >= exp_refs(400) - 1 && d <= exp_refs(400) + 1, "R8 pace after overflow", d, exp_refs(400));
        chk(we_n, "R7 we_n idle", we_n, 1);

        // reset clears
        rst = 1'b1; wait_cyc(3);
        chk(!ovf_err && host_hold, "R12 reset clears error", {ovf_err, host_hold}, 1);
        rst = 1'b0; wait_cyc(5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule